// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache. Every entry describes a pair of adjacent virtual pages that share one tag. The even page and the odd page each have their own physical frame, valid bit and dirty bit. Each entry has its own page-size mask, so one buffer can hold small and large page pairs side by side. An entry can belong to one address space, named by an 8-bit identifier, or it can be global and match in every address space.

A lookup presents a virtual address, a read/write flag and the current address-space identifier. All entries are compared in parallel. One clock edge later the block returns a result code and, on success, the physical address and a write-permission flag. The codes are hit, no match, invalid half and write to a clean page. A separate write port loads one whole entry per cycle at a given index. Choosing which entry to replace is left to the surrounding logic.

Top module: `tlb_pair_lookup`

## Requirements
- R1: While reset is high, and on the first edge after it falls, res_valid is low. Reset clears every field of every entry to zero. After reset, a lookup with identifier 0 at any address inside the pair at virtual base 0 returns code 2 (invalid). The same lookup with any other identifier returns code 1 (no match).
- R2: A lookup presented with lk_valid high at a rising edge produces res_valid high after that edge, for one cycle per request. res_valid is low after any edge at which lk_valid was low.
- R3: An entry takes part in a match only if its global bit is set or its stored identifier equals cur_asid.
- R4: The effective mask is the entry's page mask ORed with 0x1FFF, so the smallest page pair spans 8 KiB. An entry's tag matches when the address with the effective-mask bits cleared equals the stored virtual page number with those bits cleared.
- R5: The highest set bit of the effective mask chooses the half. If the address has that bit at 0, the even half (frame 0, v0, d0) is used. If it is 1, the odd half (frame 1, v1, d1) is used.
- R6: If the chosen half's valid bit is clear, the code is 2 (invalid). res_pa is 0 and res_writable is 0.
- R7: A write lookup to a valid half whose dirty bit is clear returns code 3 (modified), with res_pa 0 and res_writable 0. A write lookup to a valid dirty half returns code 0 (hit).
- R8: On code 0 (hit), res_pa equals the chosen frame ORed with the address bits under the effective mask shifted right by one. A read lookup to a valid half always returns a hit.
- R9: If no entry matches, the code is 1 (no match), with res_pa 0 and res_writable 0.
- R10: On a hit, res_writable equals the chosen half's dirty bit. A read hit on a clean half therefore reports read-only access.
- R11: If several entries match, the entry with the lowest index supplies the result.
- R12: An entry written at an edge is seen by lookups presented at later edges. A lookup presented at the same edge as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| cur_asid | input | ASID_W | Current address-space identifier |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | IDX_W | Entry index to load |
| wr_vpn | input | VA_W | Virtual page-pair number (address form) |
| wr_pmask | input | VA_W | Page mask (bits above the 8 KiB floor) |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches every identifier |
| wr_frame0 | input | PA_W | Physical frame base of the even half |
| wr_frame1 | input | PA_W | Physical frame base of the odd half |
| wr_v0 | input | 1 | Even half valid |
| wr_v1 | input | 1 | Odd half valid |
| wr_d0 | input | 1 | Even half dirty (writable) |
| wr_d1 | input | 1 | Odd half dirty (writable) |
| res_valid | output | 1 | Result available |
| res_code | output | 2 | 0 hit, 1 no match, 2 invalid, 3 modified |
| res_pa | output | PA_W | Physical address on a hit, else 0 |
| res_writable | output | 1 | Hit on a dirty half |

## Verification
The bench builds the block with 8 entries and 32-bit virtual and physical addresses. With only 8 entries, random tags drawn from a small pool of page-pair numbers and identifiers often collide. That makes multi-entry matches, global overrides and identifier misses common, so the lowest-index rule is tested many times. The random masks range from the 8 KiB floor up to 1 MiB pairs, so the even/odd select bit moves across eight positions.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  typedef enum logic [1:0] {
    RES_HIT      = 2'd0,
    RES_MISS     = 2'd1,
    RES_INVALID  = 2'd2,
    RES_MODIFIED = 2'd3
  } tlb_res_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PA_W-1:0]   wr_frame0,
  input  logic [PA_W-1:0]   wr_frame1,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic              wr_d0,
  input  logic              wr_d1,
  output logic [VA_W-1:0]   e_vpn    [ENTRIES],
  output logic [VA_W-1:0]   e_pmask  [ENTRIES],
  output logic [ASID_W-1:0] e_asid   [ENTRIES],
  output logic              e_global [ENTRIES],
  output logic [PA_W-1:0]   e_frame0 [ENTRIES],
  output logic [PA_W-1:0]   e_frame1 [ENTRIES],
  output logic [1:0]        e_valid  [ENTRIES],
  output logic [1:0]        e_dirty  [ENTRIES]
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        e_vpn[i]    <= '0;
        e_pmask[i]  <= '0;
        e_asid[i]   <= '0;
        e_global[i] <= 1'b0;
        e_frame0[i] <= '0;
        e_frame1[i] <= '0;
        e_valid[i]  <= 2'b00;
        e_dirty[i]  <= 2'b00;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        e_vpn[i]    <= wr_vpn;
        e_pmask[i]  <= wr_pmask;
        e_asid[i]   <= wr_asid;
        e_global[i] <= wr_global;
        e_frame0[i] <= wr_frame0;
        e_frame1[i] <= wr_frame1;
        e_valid[i]  <= {wr_v1, wr_v0};
        e_dirty[i]  <= {wr_d1, wr_d0};
      end
    end
  end
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int ENTRIES       = 16,
  parameter int VA_W          = 32,
  parameter int ASID_W        = 8,
  parameter int MIN_PAIR_BITS = 13
) (
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VA_W-1:0]   e_vpn    [ENTRIES],
  input  logic [VA_W-1:0]   e_pmask  [ENTRIES],
  input  logic [ASID_W-1:0] e_asid   [ENTRIES],
  input  logic              e_global [ENTRIES],
  output logic [ENTRIES-1:0] hit,
  output logic [ENTRIES-1:0] odd
);
  localparam logic [VA_W-1:0] FLOOR_MASK = VA_W'((64'd1 << MIN_PAIR_BITS) - 64'd1);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VA_W-1:0] mask;
    logic            id_ok;
    logic            tag_ok;
    assign mask   = e_pmask[i] | FLOOR_MASK;
    assign id_ok  = e_global[i] || (e_asid[i] == cur_asid);
    assign tag_ok = (va & ~mask) == (e_vpn[i] & ~mask);
    assign hit[i] = id_ok && tag_ok;
    assign odd[i] = |(va & mask & ~(mask >> 1));
  end
endmodule

// File: rtl/tlb_prio_select.sv
module tlb_prio_select #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit,
  output logic               any_hit,
  output logic [IDX_W-1:0]   sel_idx
);
  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) sel_idx = IDX_W'(i);
    end
  end
  assign any_hit = |hit;
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int ENTRIES       = 16,
  parameter int VA_W          = 32,
  parameter int PA_W          = 32,
  parameter int ASID_W        = 8,
  parameter int MIN_PAIR_BITS = 13,
  localparam int IDX_W        = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_write,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PA_W-1:0]   wr_frame0,
  input  logic [PA_W-1:0]   wr_frame1,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic              wr_d0,
  input  logic              wr_d1,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [PA_W-1:0]   res_pa,
  output logic              res_writable
);
  localparam logic [VA_W-1:0] FLOOR_MASK = VA_W'((64'd1 << MIN_PAIR_BITS) - 64'd1);

  logic [VA_W-1:0]   e_vpn    [ENTRIES];
  logic [VA_W-1:0]   e_pmask  [ENTRIES];
  logic [ASID_W-1:0] e_asid   [ENTRIES];
  logic              e_global [ENTRIES];
  logic [PA_W-1:0]   e_frame0 [ENTRIES];
  logic [PA_W-1:0]   e_frame1 [ENTRIES];
  logic [1:0]        e_valid  [ENTRIES];
  logic [1:0]        e_dirty  [ENTRIES];

  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] odd;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_frame0(wr_frame0), .wr_frame1(wr_frame1),
    .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_d0(wr_d0), .wr_d1(wr_d1),
    .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid), .e_global(e_global),
    .e_frame0(e_frame0), .e_frame1(e_frame1), .e_valid(e_valid), .e_dirty(e_dirty)
  );

  tlb_tag_match #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W), .MIN_PAIR_BITS(MIN_PAIR_BITS)
  ) u_match (
    .va(lk_va), .cur_asid(cur_asid), .e_vpn(e_vpn), .e_pmask(e_pmask),
    .e_asid(e_asid), .e_global(e_global), .hit(hit), .odd(odd)
  );

  tlb_prio_select #(.ENTRIES(ENTRIES)) u_prio (
    .hit(hit), .any_hit(any_hit), .sel_idx(sel_idx)
  );

  logic            s_odd;
  logic            s_valid;
  logic            s_dirty;
  logic [VA_W-1:0] s_half;
  logic [PA_W-1:0] s_frame;
  tlb_res_e        n_code;
  logic [PA_W-1:0] n_pa;

  always_comb begin
    s_odd   = odd[sel_idx];
    s_valid = s_odd ? e_valid[sel_idx][1] : e_valid[sel_idx][0];
    s_dirty = s_odd ? e_dirty[sel_idx][1] : e_dirty[sel_idx][0];
    s_frame = s_odd ? e_frame1[sel_idx] : e_frame0[sel_idx];
    s_half  = (e_pmask[sel_idx] | FLOOR_MASK) >> 1;
    if (!any_hit)                n_code = RES_MISS;
    else if (!s_valid)           n_code = RES_INVALID;
    else if (lk_write && !s_dirty) n_code = RES_MODIFIED;
    else                         n_code = RES_HIT;
    n_pa = (n_code == RES_HIT) ? (s_frame | (lk_va[PA_W-1:0] & s_half[PA_W-1:0])) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_code     <= RES_HIT;
      res_pa       <= '0;
      res_writable <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_code     <= n_code;
        res_pa       <= n_pa;
        res_writable <= (n_code == RES_HIT) && s_dirty;
      end
    end
  end
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic            lk_write,
  input logic            res_valid,
  input logic [1:0]      res_code,
  input logic [PA_W-1:0] res_pa,
  input logic            res_writable
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !res_valid);
  // R2
  req_to_result_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  // R2
  no_req_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  // R6
  fault_no_pa_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code != 2'd0) |-> (res_pa == '0 && !res_writable));
  // R10
  writable_only_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_writable) |-> res_code == 2'd0);
  // R7
  modified_needs_store_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !lk_write |=> !(res_valid && res_code == 2'd3));
  // R7
  store_hit_writable_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_write |=> (res_code != 2'd0 || res_writable));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
  .res_valid(res_valid), .res_code(res_code), .res_pa(res_pa),
  .res_writable(res_writable)
);

// File: tb/tlb_pair_lookup_test.sv
`timescale 1ns/1ps
module tlb_pair_lookup_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, lk_write = 0;
  logic [31:0] lk_va = 0;
  logic [7:0] cur_asid = 0;
  logic wr_en = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [31:0] wr_vpn = 0, wr_pmask = 0, wr_frame0 = 0, wr_frame1 = 0;
  logic [7:0] wr_asid = 0;
  logic wr_global = 0, wr_v0 = 0, wr_v1 = 0, wr_d0 = 0, wr_d1 = 0;
  logic res_valid, res_writable;
  logic [1:0] res_code;
  logic [31:0] res_pa;

  always #4 clk = ~clk;

  tlb_pair_lookup #(.ENTRIES(N), .VA_W(32), .PA_W(32), .ASID_W(8)) uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
    .cur_asid(cur_asid), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_frame0(wr_frame0), .wr_frame1(wr_frame1), .wr_v0(wr_v0), .wr_v1(wr_v1),
    .wr_d0(wr_d0), .wr_d1(wr_d1), .res_valid(res_valid), .res_code(res_code),
    .res_pa(res_pa), .res_writable(res_writable)
  );

  // bench record of what was loaded
  logic [31:0] m_vpn [N], m_pm [N], m_f0 [N], m_f1 [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N], m_v0 [N], m_v1 [N], m_d0 [N], m_d1 [N];

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_of(input logic [31:0] va, input logic w, input logic [7:0] asid,
                           output logic [1:0] c, output logic [31:0] pa, output logic wb);
    bit found;
    int top;
    logic [31:0] m;
    logic sel_v, sel_d;
    logic [31:0] fr;
    found = 0; c = 2'd1; pa = 0; wb = 0;
    for (int i = 0; i < N; i++) begin
      if (!found) begin
        m = m_pm[i] | 32'h1FFF;
        if ((m_g[i] || m_asid[i] == asid) && ((va & ~m) == (m_vpn[i] & ~m))) begin
          found = 1;
          top = 0;
          for (int b = 0; b < 32; b++) if (m[b]) top = b;
          sel_v = va[top] ? m_v1[i] : m_v0[i];
          sel_d = va[top] ? m_d1[i] : m_d0[i];
          fr    = va[top] ? m_f1[i] : m_f0[i];
          if (!sel_v) c = 2'd2;
          else if (w && !sel_d) c = 2'd3;
          else begin
            c = 2'd0;
            pa = fr | (va & (m >> 1));
            wb = sel_d;
          end
        end
      end
    end
  endtask

  task automatic set_wr(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                        input logic [7:0] asid, input logic g, input logic [31:0] f0,
                        input logic [31:0] f1, input logic v0, input logic v1,
                        input logic d0, input logic d1);
    wr_en = 1; wr_idx = IW'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
    wr_global = g; wr_frame0 = f0; wr_frame1 = f1; wr_v0 = v0; wr_v1 = v1;
    wr_d0 = d0; wr_d1 = d1;
  endtask

  task automatic rec_wr;
    m_vpn[wr_idx] = wr_vpn; m_pm[wr_idx] = wr_pmask; m_asid[wr_idx] = wr_asid;
    m_g[wr_idx] = wr_global; m_f0[wr_idx] = wr_frame0; m_f1[wr_idx] = wr_frame1;
    m_v0[wr_idx] = wr_v0; m_v1[wr_idx] = wr_v1; m_d0[wr_idx] = wr_d0; m_d1[wr_idx] = wr_d1;
  endtask

  task automatic load(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                      input logic [7:0] asid, input logic g, input logic [31:0] f0,
                      input logic [31:0] f1, input logic v0, input logic v1,
                      input logic d0, input logic d1);
    @(negedge clk);
    set_wr(idx, vpn, pm, asid, g, f0, f1, v0, v1, d0, d1);
    rec_wr();
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic compare(input string tag, input logic [1:0] ec, input logic [31:0] ep,
                         input logic ew);
    n_vec++;
    if (!res_valid || res_code !== ec || res_pa !== ep || res_writable !== ew) begin
      n_bad++;
      $display("FAIL %s: valid %0b code %0d pa %h wr %0b, expected valid 1 code %0d pa %h wr %0b",
               tag, res_valid, res_code, res_pa, res_writable, ec, ep, ew);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic w,
                      input logic [7:0] asid);
    logic [1:0] ec; logic [31:0] ep; logic ew;
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_write = w; cur_asid = asid;
    expect_of(va, w, asid, ec, ep, ew);
    @(negedge clk);
    lk_valid = 0;
    compare(tag, ec, ep, ew);
  endtask

  task automatic look_fixed(input string tag, input logic [31:0] va, input logic w,
                            input logic [7:0] asid, input logic [1:0] ec,
                            input logic [31:0] ep, input logic ew);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_write = w; cur_asid = asid;
    @(negedge clk);
    lk_valid = 0;
    compare(tag, ec, ep, ew);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    int unused;
    logic [31:0] pm, vpn, va;
    int k, e;
    unused = $urandom(32'd2718);
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 0; m_pm[i] = 0; m_f0[i] = 0; m_f1[i] = 0; m_asid[i] = 0;
      m_g[i] = 0; m_v0[i] = 0; m_v1[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
    end
    repeat (3) @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1: res_valid %0b during reset, expected 0", res_valid);
    end
    rst = 0;
    @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1: res_valid %0b after reset, expected 0", res_valid);
    end
    // R1: cleared entries all match identifier 0 at base 0, halves invalid
    look_fixed("R1 cleared entry id 0", 32'h0000_1234, 0, 8'd0, 2'd2, 0, 0);
    look_fixed("R1 cleared entry other id", 32'h0000_1234, 0, 8'd5, 2'd1, 0, 0);

    // R2: no request gives no result
    @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0) begin
      n_bad++; $display("FAIL R2: res_valid %0b with no request, expected 0", res_valid);
    end

    // directed entries
    load(0, 32'h0040_0000, 32'h0, 8'd7, 0, 32'h1000_0000, 32'h2000_1000, 1, 1, 0, 1);
    // R8/R10 even half read hit, clean -> read-only
    look_fixed("R8 even read", 32'h0040_0ABC, 0, 8'd7, 2'd0, 32'h1000_0ABC, 0);
    // R5 odd half, dirty -> writable
    look_fixed("R5 odd read", 32'h0040_1F00, 0, 8'd7, 2'd0, 32'h2000_1F00, 1);
    // R7 write to clean even half
    look_fixed("R7 store clean", 32'h0040_0004, 1, 8'd7, 2'd3, 0, 0);
    // R7 write to dirty odd half
    look_fixed("R7 store dirty", 32'h0040_1004, 1, 8'd7, 2'd0, 32'h2000_1004, 1);
    // R3 identifier mismatch
    look_fixed("R3 id mismatch", 32'h0040_0004, 0, 8'd8, 2'd1, 0, 0);
    // R9 tag miss
    look_fixed("R9 tag miss", 32'h0040_2004, 0, 8'd7, 2'd1, 0, 0);
    // R3 global entry matches any identifier; R6 invalid odd half
    load(1, 32'h0080_0000, 32'h0, 8'd1, 1, 32'h3000_0000, 32'h3000_1000, 1, 0, 1, 1);
    look_fixed("R3 global", 32'h0080_0010, 0, 8'd99, 2'd0, 32'h3000_0010, 1);
    look_fixed("R6 invalid half", 32'h0080_1010, 1, 8'd99, 2'd2, 0, 0);
    // R4/R5 large mask: pair 128 KiB, select bit 16
    load(2, 32'h0100_0000, 32'h0001_E000, 8'd7, 0, 32'h4000_0000, 32'h5000_0000, 1, 1, 1, 1);
    look_fixed("R4 big page even", 32'h0100_E123, 0, 8'd7, 2'd0, 32'h4000_E123, 1);
    look_fixed("R5 big page odd", 32'h0101_2345, 0, 8'd7, 2'd0, 32'h5000_2345, 1);
    // R4 tag stored with low bits set still matches
    load(3, 32'h0200_1FFF, 32'h0, 8'd7, 0, 32'h6000_0000, 32'h6100_0000, 1, 1, 1, 1);
    look_fixed("R4 masked tag", 32'h0200_0008, 0, 8'd7, 2'd0, 32'h6000_0008, 1);
    // R11 two matching entries, lower index wins
    load(5, 32'h0300_0000, 32'h0, 8'd7, 0, 32'h7700_0000, 32'h7700_1000, 1, 1, 1, 1);
    load(4, 32'h0300_0000, 32'h0, 8'd0, 1, 32'h7400_0000, 32'h7400_1000, 1, 1, 0, 0);
    look_fixed("R11 lowest index", 32'h0300_0040, 0, 8'd7, 2'd0, 32'h7400_0040, 0);
    // R12 write and lookup at the same edge: old contents seen
    @(negedge clk);
    set_wr(6, 32'h0500_0000, 32'h0, 8'd7, 0, 32'h0900_0000, 32'h0900_1000, 1, 1, 1, 1);
    lk_valid = 1; lk_va = 32'h0500_0020; lk_write = 0; cur_asid = 8'd7;
    @(negedge clk);
    rec_wr();
    wr_en = 0; lk_valid = 0;
    compare("R12 same-edge old", 2'd1, 0, 0);
    look_fixed("R12 next edge new", 32'h0500_0020, 0, 8'd7, 2'd0, 32'h0900_0020, 1);

    // random phase
    for (int r = 0; r < 2000; r++) begin
      if ((r % 40) == 0) begin
        for (int i = 0; i < N; i++) begin
          k = $urandom % 8;
          pm = ((32'd1 << k) - 32'd1) << 13;
          vpn = (($urandom % 6) << 20) | ($urandom & 32'h000F_E000);
          load(i, vpn, pm, 8'($urandom % 4), ($urandom % 8) == 0,
               $urandom & 32'hFFF0_0000, $urandom & 32'hFFF0_0000,
               $urandom % 4 != 0, $urandom % 4 != 0, $urandom % 2, $urandom % 2);
        end
      end
      e = $urandom % N;
      va = (m_vpn[e] & 32'hFFF0_0000) | ($urandom & 32'h000F_FFFF);
      if ($urandom % 8 == 0) va = $urandom;
      look("R8 random", va, $urandom % 2, 8'($urandom % 4));
    end
    summary();
  end
endmodule